// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

A single timer channel that counts a register down once per prescaled tick of the peripheral clock. The prescaler divides by 4, 16, 64, 256 or 1024, chosen by a three-bit code in the control register. When a tick arrives while the counter already holds zero, the counter is refilled from a reload register instead of wrapping. That event also sets a sticky underflow flag. The flag drives a level interrupt whenever the interrupt enable bit is also set.

Software reaches the channel through a four-entry, word-indexed register port. Writes take effect on the next clock edge, and reads are combinational. Counting is gated by `run_en`, which comes from a start register outside the channel. Writing the control register while the channel runs pauses counting for that one cycle and applies the new prescaler code. The counter value is not touched. When the `HAS_CAPTURE` parameter is set, a fourth register is present as plain storage.

Top module: `rtmr_channel`

## Requirements
- R1: After reset, the reload register (index 0) and the counter (index 1) both read 0xFFFFFFFF, the control register (index 2) reads 0, the capture register (index 3) reads 0, and `irq` is low.
- R2: Control bits [2:0] hold the prescaler code c (0 to 4). While running, the counter decrements once every 4 << (2*c) clock cycles, counted from the cycle `run_en` was first seen high.
- R3: Prescaler codes 5, 6 and 7 never advance the counter, even while `run_en` is high.
- R4: While `run_en` is low, the counter holds its value unless software writes it.
- R5: A tick that arrives while the counter is 0 loads the counter from the reload register and sets the underflow flag, which reads back at control bit 8.
- R6: Writing 0 to control bit 8 clears the flag. Writing 1 leaves it unchanged, so software can never set the flag.
- R7: `irq` is high exactly when the underflow flag and the interrupt enable (control bit 5) are both set.
- R8: Control bit 9 always reads 0. Control bits [7:0] other than the flag, and bits [15:10], read back the value written. Bits [31:16] read 0.
- R9: With `HAS_CAPTURE` set, index 3 is a read/write register.
- R10: A control write while running leaves the counter unchanged. If the write changes the prescaler code, the next decrement comes one full new period after the write edge.
- R11: A counter write wins over a tick in the same cycle. The prescaler still wraps on that tick, so the next decrement comes one full period after the write.
- R12: Register indices are 0 = reload, 1 = counter, 2 = control, 3 = capture. These correspond to byte offsets 0x0, 0x4, 0x8 and 0xC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Channel start bit from the outer start register |
| wr_en | input | 1 | Register write strobe |
| reg_idx | input | 2 | Word index of the register accessed |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Combinational read data for `reg_idx` |
| irq | output | 1 | Level interrupt: underflow flag AND enable |

## Verification
Register writes become visible at the negative edge that follows the write's clock edge, and reads are sampled 1 ns after `reg_idx` is set at a negative edge. With code c, a decrement lands on the P-th rising edge of running, where P = 4 << 2c. The bench therefore reads the counter at every negative edge and compares it against floor(k/P) ticks applied to the known start value, with `irq` expected high from the third tick on. For a control write that changes the code in mid-run, the write edge itself is a pause, and the counter must move on exactly the 16th edge after it. For a counter write that collides with a tick, the written value must appear at once and drop by one on the 4th edge after.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int CTRL_W   = 16;
  localparam int DIV_W    = 10;
  localparam int PSC_MAX  = 4;
  localparam int IE_BIT   = 5;
  localparam int UF_BIT   = 8;
  localparam int RSV_LSB  = 10;

  typedef enum logic [1:0] {
    IDX_RELOAD = 2'd0,
    IDX_COUNT  = 2'd1,
    IDX_CTRL   = 2'd2,
    IDX_CAPT   = 2'd3
  } reg_idx_e;

  function automatic logic psc_code_ok(input logic [2:0] code);
    return code <= 3'(PSC_MAX);
  endfunction

  // Division ratio for a legal code: 4^(code+1).
  function automatic logic [DIV_W:0] psc_period(input logic [2:0] code);
    return (DIV_W+1)'(4) << {code, 1'b0};
  endfunction
endpackage

// File: rtl/rtmr_prescaler.sv
module rtmr_prescaler
  import rtmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       hold,
  input  logic       code_chg,
  input  logic [2:0] code,
  output logic       tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   period;
  logic             at_end;
  logic             ok;

  assign period = psc_period(code);
  assign ok     = psc_code_ok(code);
  assign at_end = ({1'b0, div_q} == (period - (DIV_W+1)'(1)));
  assign tick   = run && ok && !hold && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      div_q <= '0;
    else if (!run || code_chg || !ok) div_q <= '0;
    else if (hold)                   div_q <= div_q;
    else if (at_end)                 div_q <= '0;
    else                             div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             uf_evt
);
  logic at_zero;

  assign at_zero = (cnt_q == '0);
  assign uf_evt  = tick && at_zero && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rld_q <= '1;
    else if (rld_wr) rld_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '1;
    else if (cnt_wr)  cnt_q <= wdata;
    else if (uf_evt)  cnt_q <= rld_q;
    else if (tick)    cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/rtmr_ctrl.sv
module rtmr_ctrl
  import rtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              uf_evt,
  output logic [2:0]        psc_code,
  output logic              irq_en,
  output logic              flag,
  output logic              code_chg,
  output logic [CTRL_W-1:0] ctrl_rd
);
  logic [7:0]              low_q;
  logic [CTRL_W-RSV_LSB-1:0] rsv_q;

  assign psc_code = low_q[2:0];
  assign irq_en   = low_q[IE_BIT];
  assign code_chg = ctrl_wr && (wdata[2:0] != low_q[2:0]);
  assign ctrl_rd  = {rsv_q, 1'b0, flag, low_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      rsv_q <= '0;
    end else if (ctrl_wr) begin
      low_q <= wdata[7:0];
      rsv_q <= wdata[CTRL_W-1:RSV_LSB];
    end
  end

  // Set by hardware only; a written 0 clears, a written 1 keeps.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flag <= 1'b0;
    else if (uf_evt)                   flag <= 1'b1;
    else if (ctrl_wr && !wdata[UF_BIT]) flag <= 1'b0;
  end
endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel
  import rtmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter bit HAS_CAPTURE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             wr_en,
  input  logic [1:0]       reg_idx,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  logic             rld_wr, cnt_wr, ctrl_wr, capt_wr;
  logic             tick, uf_evt, code_chg, irq_en, flag;
  logic [2:0]       psc_code;
  logic [CNT_W-1:0] cnt_q, rld_q, capt_q;
  logic [CTRL_W-1:0] ctrl_rd;

  assign rld_wr  = wr_en && (reg_idx == IDX_RELOAD);
  assign cnt_wr  = wr_en && (reg_idx == IDX_COUNT);
  assign ctrl_wr = wr_en && (reg_idx == IDX_CTRL);
  assign capt_wr = wr_en && (reg_idx == IDX_CAPT);

  rtmr_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_en), .hold(ctrl_wr),
    .code_chg(code_chg), .code(psc_code), .tick(tick)
  );

  rtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
    .rld_wr(rld_wr), .wdata(wr_data), .cnt_q(cnt_q), .rld_q(rld_q),
    .uf_evt(uf_evt)
  );

  rtmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .wdata(wr_data[CTRL_W-1:0]), .uf_evt(uf_evt), .psc_code(psc_code),
    .irq_en(irq_en), .flag(flag), .code_chg(code_chg), .ctrl_rd(ctrl_rd)
  );

  generate
    if (HAS_CAPTURE) begin : g_capt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       capt_q <= '0;
        else if (capt_wr) capt_q <= wr_data;
      end
    end else begin : g_no_capt
      assign capt_q = '0;
    end
  endgenerate

  always_comb begin
    unique case (reg_idx)
      IDX_RELOAD: rd_data = rld_q;
      IDX_COUNT:  rd_data = cnt_q;
      IDX_CTRL:   rd_data = CNT_W'(ctrl_rd);
      default:    rd_data = capt_q;
    endcase
  end

  assign irq = flag && irq_en;
endmodule

// File: rtl/rtmr_channel_chk.sv
module rtmr_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             tick,
  input logic             uf_evt,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rld_q,
  input logic             flag,
  input logic [2:0]       psc_code
);
  assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> $stable(cnt_q));

  assert_reserved_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psc_code > 3'd4) |-> !tick);

  assert_reload_on_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> (cnt_q == $past(rld_q)));

  assert_flag_after_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> flag);

  assert_flag_rises_only_by_hw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(uf_evt));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !uf_evt);
endmodule

bind rtmr_channel rtmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .uf_evt(uf_evt),
  .cnt_wr(cnt_wr), .cnt_q(cnt_q), .rld_q(rld_q), .flag(flag),
  .psc_code(psc_code)
);

// File: tb/rtmr_channel_bench.sv
`timescale 1ns/1ps
module rtmr_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  reg_idx = 2'd1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int checks = 0;
  int errors = 0;

  rtmr_channel u_rtmr_channel (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
    .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; reg_idx = 2'd1;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    reg_idx = idx;
    #1;
    d = rd_data;
    reg_idx = 2'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 and R12 reset values per index
    rd(2'd0, v); chk("R1 reload reset", v, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R1 counter reset", v, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R1 control reset", v, 32'h0);
    rd(2'd3, v); chk("R1 capture reset", v, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    // R2 / R5 / R7 sweep over every legal prescaler code
    for (int c = 0; c <= 4; c++) begin
      int p;
      p = 4 << (2 * c);
      wr(2'd0, 32'd2);
      wr(2'd1, 32'd2);
      wr(2'd2, 32'h20 | c);
      run_en = 1'b1;
      for (int k = 1; k <= 3 * p; k++) begin
        int n;
        @(negedge clk);
        n = k / p;
        rd(2'd1, v); chk($sformatf("R2 code %0d cycle %0d", c, k), v, 32'(2 - (n % 3)));
        chk($sformatf("R7 irq code %0d cycle %0d", c, k), {31'b0, irq}, {31'b0, n >= 3});
      end
      run_en = 1'b0;
      rd(2'd2, v); chk("R5 flag after underflow", v, 32'h120 | c);
    end

    // R6 / R8 flag write semantics (flag=1, ie=1, code 4 present)
    wr(2'd2, 32'h320);
    rd(2'd2, v); chk("R6 R8 write 1 keeps flag, bit9 zero", v, 32'h120);
    chk("R7 irq stays", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R6 write 0 clears flag", v, 32'h0);
    chk("R7 irq low after clear", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h100);
    rd(2'd2, v); chk("R6 software cannot set flag", v, 32'h0);

    // R5 / R7 masking: underflow with ie=0
    wr(2'd0, 32'd5);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'h0);
    run_en = 1'b1;
    repeat (4) @(negedge clk);
    run_en = 1'b0;
    rd(2'd1, v); chk("R5 reload loaded", v, 32'd5);
    rd(2'd2, v); chk("R5 flag set", v, 32'h100);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk("R4 hold while stopped", v, 32'd5);
    wr(2'd2, 32'h120);
    chk("R7 irq when enabled", {31'b0, irq}, 32'h1);

    // R8 readback and R3 reserved codes
    wr(2'd2, 32'hFFFF_FCCD);
    rd(2'd2, v); chk("R8 control readback", v, 32'h0000_FCCD);
    for (int c = 5; c <= 7; c++) begin
      run_en = 1'b0;
      wr(2'd2, 32'(c));
      wr(2'd1, 32'd7);
      run_en = 1'b1;
      repeat (150) @(negedge clk);
      rd(2'd1, v); chk($sformatf("R3 code %0d no count", c), v, 32'd7);
    end
    run_en = 1'b0;

    // R10 control write in mid-run
    wr(2'd0, 32'd50);
    wr(2'd1, 32'd10);
    wr(2'd2, 32'h0);
    run_en = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd1, v); chk("R10 before write", v, 32'd9);
    wr(2'd2, 32'h1);
    rd(2'd1, v); chk("R10 unchanged by write", v, 32'd9);
    repeat (15) @(negedge clk);
    rd(2'd1, v); chk("R10 no tick before new period", v, 32'd9);
    @(negedge clk);
    rd(2'd1, v); chk("R10 tick after new period", v, 32'd8);
    run_en = 1'b0;

    // R11 counter write colliding with a tick
    wr(2'd2, 32'h0);
    wr(2'd1, 32'd20);
    run_en = 1'b1;
    repeat (3) @(negedge clk);
    wr_en = 1'b1; reg_idx = 2'd1; wr_data = 32'd100;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd1, v); chk("R11 write wins", v, 32'd100);
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk("R11 held until next period", v, 32'd100);
    @(negedge clk);
    rd(2'd1, v); chk("R11 next decrement", v, 32'd99);
    run_en = 1'b0;
    rd(2'd2, v); chk("R11 no underflow flag", v, 32'h0);

    // R9 / R12 register map
    wr(2'd3, 32'h1234_5678);
    wr(2'd0, 32'hA5A5_0F0F);
    rd(2'd3, v); chk("R9 capture readback", v, 32'h1234_5678);
    rd(2'd0, v); chk("R12 reload index 0", v, 32'hA5A5_0F0F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule